// File: doc/BRIEF.md
# Power-Fail and Pushbutton Reset Sequencer

This block owns an active-low, open-drain reset line and a flag that keeps the host bus away from the device while a reset is in progress. It holds reset low for as long as the supply monitor reports a power failure. Once the supply is good again it keeps reset low for a fixed stretch, counted on a 4096 Hz tick enable, which is 250 ms at the default setting. If the oscillator was switched off for battery operation, it also waits for the oscillator to report that it is running.

A pushbutton may pull the same pin low. The sequencer reads the pin back through a synchronizer and watches for a falling edge. When it sees one, it drives a timed pulse. If the button is still held after that pulse, it waits for the release and then drives a second timed pulse, so that bounce at both ends of the press is absorbed. The sequencer ignores the low level that its own drive puts on the pin.

Another block, for example an expired watchdog, can ask for the same timed pulse. The supply monitor overrides every other activity.

Top module: `reset_supervisor`

## Requirements
- R1: While `pwr_fail_i` is high, `rst_drive_o` and `access_block_o` are both high from the next clock edge onward, whatever the current state.
- R2: After `pwr_fail_i` falls, `rst_drive_o` stays high for exactly `PULSE_TICKS` clock edges that sample `tick_i` high, not counting the edge on which the stretch begins, and is then released.
- R3: If `osc_off_i` is high and `osc_ready_i` is low when the stretch ends, `rst_drive_o` stays high until `osc_ready_i` rises and falls on the clock edge after that. If the oscillator is already ready, the stretch lasts exactly `PULSE_TICKS` ticks.
- R4: Reset (`rst_n` low) puts the block into the post-power stretch. `rst_drive_o` and `access_block_o` read 1, and the stretch lasts `PULSE_TICKS` ticks after `rst_n` rises.
- R5: In the idle state, a fall of `pin_i` from 1 to 0 sets `rst_drive_o` on the third clock edge after the fall (two synchronizer flops and one edge register). The pulse then lasts `PULSE_TICKS` ticks.
- R6: If the pin is still low `SYNC_STAGES`+1 cycles after the press pulse ends, the block releases its drive and waits with `rst_drive_o` = 0 and `access_block_o` = 1.
- R7: While it waits, a rise of `pin_i` sets `rst_drive_o` on the third clock edge after the rise, for another `PULSE_TICKS` ticks.
- R8: If the pin reads high after the press pulse, the block returns to idle with both outputs 0 and drives no second pulse.
- R9: A high `pulse_req_i` in the idle state sets `rst_drive_o` on the next edge for `PULSE_TICKS` ticks. The low level that this drive puts on the pin does not start a further pulse.
- R10: `pulse_req_i` has no effect in any state other than idle.
- R11: A power failure cuts short a pushbutton pulse that is in progress. The full post-power stretch follows.
- R12: `access_block_o` is high in every state except idle and the re-arm wait. It is always high while `rst_drive_o` is high.
- R13: After the block releases the pin, edge detection stays disarmed until the synchronized pin reads high. A pin that is held low externally starts no pulse, and a later press after the pin has gone high is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail_i | input | 1 | Supply out of tolerance |
| osc_off_i | input | 1 | Oscillator disabled for battery operation |
| osc_ready_i | input | 1 | Oscillator running and stable |
| pin_i | input | 1 | Level read back from the reset pin (asynchronous) |
| pulse_req_i | input | 1 | Request for a timed reset pulse from another block |
| tick_i | input | 1 | 4096 Hz single-cycle enable |
| rst_drive_o | output | 1 | 1 = pull the reset pin low |
| access_block_o | output | 1 | 1 = refuse bus accesses |

## Verification
On every cycle the assertions check four things: that a power failure forces both the drive and the bus block on the following edge, that no driven pulse ends before `PULSE_TICKS` ticks have passed, and that a post-power release with the oscillator disabled never comes before the oscillator is ready. Other behaviour only the bench scenarios can show. This covers the exact three-edge latency of edge detection through the synchronizer, the decision between the held and the released button, the second pulse on release, the ignored requests outside idle, and the disarmed detector while the pin is held low from outside. The bench sweeps the tick spacing and the oscillator delay so that the expected pulse lengths can be worked out in ticks.

// File: rtl/rsup_pkg.sv
// Shared state encoding for the reset sequencer and helpers that decode it.
// Assumes: states are only produced by rsup_fsm.
package rsup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_PWRFAIL = 4'd1,
        ST_STRETCH = 4'd2,
        ST_OSCWAIT = 4'd3,
        ST_PRESS   = 4'd4,
        ST_CHECK   = 4'd5,
        ST_HELD    = 4'd6,
        ST_RELEASE = 4'd7,
        ST_REQ     = 4'd8,
        ST_REARM   = 4'd9
    } sup_state_e;

    // True for states in which the block pulls the pin low.
    function automatic logic drives_pin(input sup_state_e st);
        return (st == ST_PWRFAIL) || (st == ST_STRETCH) || (st == ST_OSCWAIT) ||
               (st == ST_PRESS)   || (st == ST_RELEASE) || (st == ST_REQ);
    endfunction

    // True for states in which bus access must be refused.
    function automatic logic blocks_bus(input sup_state_e st);
        return (st != ST_IDLE) && (st != ST_REARM);
    endfunction

endpackage

// File: rtl/rsup_pin_sync.sv
// Brings the asynchronous pin level into the clock domain through SYNC_STAGES
// flops and keeps one extra delayed copy for edge detection.
// Assumes: the idle pin level is high, so every flop resets to 1.
module rsup_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_s_o,
    output logic pin_prev_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // Later stages shift the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign pin_s_o    = chain_q[SYNC_STAGES-1];
    assign pin_prev_o = prev_q;

endmodule

// File: rtl/rsup_tick_timer.sv
// Counts tick enables since the last clear and flags the tick that completes
// PULSE_TICKS of them. Saturates afterwards.
// Assumes: PULSE_TICKS >= 2.
module rsup_tick_timer #(
    parameter int PULSE_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int TW = $clog2(PULSE_TICKS);
    localparam logic [TW-1:0] LAST = TW'(PULSE_TICKS - 1);

    logic [TW-1:0] cnt_q;

    // Tick counter, cleared on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr_i)                   cnt_q <= '0;
        else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = tick_i && (cnt_q == LAST);

endmodule

// File: rtl/rsup_fsm.sv
// Sequencing state machine: power-fail hold, post-power stretch, oscillator
// wait, the press and release pulses of the pushbutton, requested pulses
// and re-arming of edge detection.
// Assumes: pin inputs are already synchronized. Timer done is one cycle wide.
module rsup_fsm
    import rsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail_i,
    input  logic       osc_off_i,
    input  logic       osc_ready_i,
    input  logic       req_i,
    input  logic       pin_s_i,
    input  logic       pin_prev_i,
    input  logic       tmr_done_i,
    output logic       tmr_clr_o,
    output sup_state_e state_o
);

    localparam int SW = $clog2(SYNC_STAGES + 1);
    localparam logic [SW-1:0] SETTLE = SW'(SYNC_STAGES);

    sup_state_e    state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          settle_done;
    logic          pin_fell, pin_rose;

    assign pin_fell    = pin_prev_i && !pin_s_i;
    assign pin_rose    = !pin_prev_i && pin_s_i;
    assign settle_done = (settle_q == SETTLE);

    // Next-state selection. Power failure overrides every state.
    always_comb begin
        state_d = state_q;
        if (pwr_fail_i) begin
            state_d = ST_PWRFAIL;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (req_i)            state_d = ST_REQ;
                            else if (pin_fell)    state_d = ST_PRESS;
                ST_PWRFAIL:                       state_d = ST_STRETCH;
                ST_STRETCH: if (tmr_done_i)       state_d = (osc_off_i && !osc_ready_i)
                                                            ? ST_OSCWAIT : ST_REARM;
                ST_OSCWAIT: if (osc_ready_i || !osc_off_i) state_d = ST_REARM;
                ST_PRESS:   if (tmr_done_i)       state_d = ST_CHECK;
                ST_CHECK:   if (settle_done)      state_d = pin_s_i ? ST_IDLE : ST_HELD;
                ST_HELD:    if (pin_rose)         state_d = ST_RELEASE;
                ST_RELEASE: if (tmr_done_i)       state_d = ST_REARM;
                ST_REQ:     if (tmr_done_i)       state_d = ST_REARM;
                ST_REARM:   if (pin_s_i)          state_d = ST_IDLE;
                default:                          state_d = ST_STRETCH;
            endcase
        end
    end

    // State register. Reset enters the post-power stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STRETCH;
        else        state_q <= state_d;
    end

    // Settle counter: cycles spent in the check state since entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  settle_q <= '0;
        else if (state_d != state_q)                 settle_q <= '0;
        else if (state_q == ST_CHECK && !settle_done) settle_q <= settle_q + 1'b1;
    end

    assign tmr_clr_o = (state_d != state_q);
    assign state_o   = state_q;

endmodule

// File: rtl/reset_supervisor.sv
// Top of the reset sequencer: pin synchronizer, tick timer and state machine.
// Outputs are decoded from the registered state, so they are free of glitches.
// Assumes: tick_i is a one-cycle enable, and pin_i already reflects the pad level.
module reset_supervisor #(
    parameter int PULSE_TICKS = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail_i,
    input  logic osc_off_i,
    input  logic osc_ready_i,
    input  logic pin_i,
    input  logic pulse_req_i,
    input  logic tick_i,
    output logic rst_drive_o,
    output logic access_block_o
);

    import rsup_pkg::*;

    logic       pin_s, pin_prev, tmr_clr, tmr_done;
    sup_state_e state;

    rsup_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .pin_s_o    (pin_s),
        .pin_prev_o (pin_prev)
    );

    rsup_tick_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (tick_i),
        .done_o (tmr_done)
    );

    rsup_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_fail_i  (pwr_fail_i),
        .osc_off_i   (osc_off_i),
        .osc_ready_i (osc_ready_i),
        .req_i       (pulse_req_i),
        .pin_s_i     (pin_s),
        .pin_prev_i  (pin_prev),
        .tmr_done_i  (tmr_done),
        .tmr_clr_o   (tmr_clr),
        .state_o     (state)
    );

    // Output decode from the registered state.
    always_comb begin
        rst_drive_o    = drives_pin(state);
        access_block_o = blocks_bus(state);
    end

endmodule

// File: rtl/reset_supervisor_chk.sv
// Property checker for reset_supervisor, attached through bind.
// Watches ports only and keeps its own tick count for each driven pulse.
module reset_supervisor_chk #(
    parameter int PULSE_TICKS = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_fail_i,
    input logic osc_off_i,
    input logic osc_ready_i,
    input logic tick_i,
    input logic rst_drive_o,
    input logic access_block_o
);

    localparam int CW = $clog2(PULSE_TICKS + 1) + 1;
    localparam logic [CW-1:0] CAP = CW'(PULSE_TICKS);

    logic [CW-1:0] seen_q;
    logic          pwr_seq_q;

    // Ticks sampled while the pin is driven, saturating at PULSE_TICKS.
    always_ff @(posedge clk) begin
        if (!rst_n)               seen_q <= '0;
        else if (!rst_drive_o)    seen_q <= '0;
        else if (tick_i && seen_q != CAP) seen_q <= seen_q + 1'b1;
    end

    // Marks a drive interval that belongs to a power sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)            pwr_seq_q <= 1'b1;
        else if (pwr_fail_i)   pwr_seq_q <= 1'b1;
        else if (!rst_drive_o) pwr_seq_q <= 1'b0;
    end

    p_pwr_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> rst_drive_o);

    p_pwr_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> access_block_o);

    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_o) |-> (seen_q == CAP));

    p_osc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_drive_o) && pwr_seq_q && $past(osc_off_i)) |-> $past(osc_ready_i));

endmodule

bind reset_supervisor reset_supervisor_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_fail_i     (pwr_fail_i),
    .osc_off_i      (osc_off_i),
    .osc_ready_i    (osc_ready_i),
    .tick_i         (tick_i),
    .rst_drive_o    (rst_drive_o),
    .access_block_o (access_block_o)
);

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;

    localparam int PT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0, osc_off = 1'b0, osc_ready = 1'b1, req = 1'b0;
    logic btn = 1'b0, ext_low = 1'b0;
    logic tick, drive, block, pin;
    int   tdiv = 1;
    int   div_q = 0;
    int   nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    // Tick generator: one enable every tdiv cycles.
    always @(posedge clk) div_q <= (div_q + 1 >= tdiv) ? 0 : div_q + 1;
    assign tick = (div_q == 0);

    // Open-drain pin: pulled low by the block, the button or another source.
    assign pin = !(drive || btn || ext_low);

    reset_supervisor #(.PULSE_TICKS(PT), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .osc_off_i(osc_off),
        .osc_ready_i(osc_ready), .pin_i(pin), .pulse_req_i(req), .tick_i(tick),
        .rst_drive_o(drive), .access_block_o(block)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts ticks while drive is high. Call at a negedge with drive high.
    task automatic measure(output int n);
        n = 0;
        for (int g = 0; g < 2000; g++) begin
            if (!drive) break;
            if (tick) n++;
            @(negedge clk);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Press the button in idle and check the three-edge latency (R5).
    task automatic press(input string tag);
        btn = 1'b1;
        @(negedge clk); chk({tag, " R5 lat1"}, drive, 0);
        @(negedge clk); chk({tag, " R5 lat2"}, drive, 0);
        @(negedge clk); chk({tag, " R5 lat3"}, drive, 1);
    endtask

    task automatic pwr_cycle(input string tag);
        int n;
        pwr_fail = 1'b1;
        cyc(1);
        chk({tag, " R1 drive"}, drive, 1);
        chk({tag, " R1 block"}, block, 1);
        cyc(3);
        pwr_fail = 1'b0;
        cyc(1);
        measure(n);
        chk({tag, " R2 stretch ticks"}, n, PT);
        cyc(6);
        chk({tag, " R12 idle block"}, block, 0);
    endtask

    initial begin
        int n;
        int hi;
        cyc(3);
        chk("R4 reset drive", drive, 1);
        chk("R4 reset block", block, 1);
        rst_n = 1'b1;
        measure(n);
        chk("R4 first stretch ticks", n, PT);
        cyc(6);
        chk("R12 idle after reset", block, 0);

        for (int td = 1; td <= 4; td++) begin
            tdiv = td;
            cyc(2);
            pwr_cycle($sformatf("tdiv%0d", td));

            // Held press: press pulse, wait, release pulse (R5 R6 R7).
            press($sformatf("held tdiv%0d", td));
            measure(n);
            chk("R5 press ticks", n, PT);
            chk("R12 check blocks", block, 1);
            cyc(8);
            chk("R6 held drive", drive, 0);
            chk("R6 held block", block, 1);
            btn = 1'b0;
            @(negedge clk); chk("R7 lat1", drive, 0);
            @(negedge clk); chk("R7 lat2", drive, 0);
            @(negedge clk); chk("R7 lat3", drive, 1);
            measure(n);
            chk("R7 release ticks", n, PT);
            cyc(6);
            chk("R7 idle after", block, 0);

            // Short press released during the pulse (R8).
            press($sformatf("short tdiv%0d", td));
            btn = 1'b0;
            measure(n);
            chk("R8 press ticks", n, PT);
            hi = 0;
            for (int k = 0; k < 20; k++) begin @(negedge clk); hi |= drive; end
            chk("R8 no second pulse", hi, 0);
            chk("R8 idle block", block, 0);

            // Requested pulse; own drive must not retrigger (R9).
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk("R9 req latency", drive, 1);
            measure(n);
            chk("R9 req ticks", n, PT);
            hi = 0;
            for (int k = 0; k < 20; k++) begin @(negedge clk); hi |= drive; end
            chk("R9 no retrigger", hi, 0);
            chk("R9 idle block", block, 0);
        end

        tdiv = 2;
        // R3 sweep: oscillator becomes ready d cycles after the stretch.
        for (int d = 0; d < 6; d++) begin
            osc_off = 1'b1; osc_ready = 1'b0;
            pwr_fail = 1'b1; cyc(3); pwr_fail = 1'b0;
            cyc(PT * tdiv + 3 + d);
            chk($sformatf("R3 hold d%0d", d), drive, 1);
            osc_ready = 1'b1;
            cyc(1);
            chk($sformatf("R3 release d%0d", d), drive, 0);
            cyc(6);
            chk("R3 idle", block, 0);
        end
        // R3: ready early, plain stretch.
        osc_off = 1'b1; osc_ready = 1'b1;
        pwr_fail = 1'b1; cyc(2); pwr_fail = 1'b0; cyc(1);
        measure(n);
        chk("R3 ready early ticks", n, PT);
        osc_off = 1'b0;
        cyc(6);

        // R10: request ignored while waiting for release.
        press("r10");
        measure(n);
        cyc(6);
        req = 1'b1;
        hi = 0;
        for (int k = 0; k < 6; k++) begin @(negedge clk); hi |= drive; end
        req = 1'b0;
        chk("R10 req ignored", hi, 0);
        chk("R10 still held block", block, 1);
        btn = 1'b0;
        cyc(3);
        chk("R10 release pulse", drive, 1);
        measure(n);
        chk("R10 release ticks", n, PT);
        cyc(6);

        // R11: power failure cuts a press pulse short.
        press("r11");
        cyc(1);
        btn = 1'b0;
        pwr_fail = 1'b1;
        cyc(1);
        chk("R11 drive", drive, 1);
        chk("R11 block", block, 1);
        cyc(4);
        pwr_fail = 1'b0;
        cyc(1);
        measure(n);
        chk("R11 stretch ticks", n, PT);
        cyc(6);
        chk("R11 idle", block, 0);

        // R13: pin held low externally after a requested pulse.
        ext_low = 1'b1;
        req = 1'b1; cyc(1); req = 1'b0;
        measure(n);
        chk("R13 req ticks", n, PT);
        hi = 0;
        for (int k = 0; k < 15; k++) begin @(negedge clk); hi |= drive; end
        chk("R13 disarmed no pulse", hi, 0);
        chk("R13 rearm no block", block, 0);
        ext_low = 1'b0;
        cyc(6);
        press("r13 rearmed");
        btn = 1'b0;
        measure(n);
        chk("R13 press ticks", n, PT);
        cyc(10);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule